// File: doc/BRIEF.md
# DSP Saturation and Rounding Unit

This unit is an arithmetic helper for a DSP datapath. It takes one 64-bit operand, a second 64-bit operand for addition, and a 3-bit opcode. The opcode selects one of six operations: signed saturation to N bits, unsigned saturation to N bits, a clip to a symmetric power-of-two window, convergent rounding, rounding to a 2^N boundary, or a 64-bit signed saturating add. The widths N and U are runtime inputs.

The result is registered, so it appears one clock after an accepted input. An overflow pulse comes out in the same cycle as the result whenever a saturation actually replaced the value. The pulse also sets a sticky overflow bit. That bit stays set until a clear input drops it. An overflow in the same cycle as a clear takes precedence over the clear. Reset is synchronous and active high.

Top module: `dsp_satrnd_unit`

## Requirements
- R1: Opcode 0 (signed saturate, N in 1..63): if the operand lies in [-(2^(N-1)), 2^(N-1)-1], the operand passes unchanged with no overflow. Otherwise the result is -(2^(N-1)) for a negative operand and 2^(N-1)-1 for a non-negative operand, with overflow.
- R2: Opcode 1 (unsigned saturate, N in 1..63): if the operand lies in [0, 2^N-1], it passes with no overflow. Otherwise the result is 0 for a negative operand and 2^N-1 for a positive operand, with overflow.
- R3: Opcode 5 (saturating add): the result is a+b wrapped to 64 bits. When a and b share a sign bit and the sum's sign bit differs from it, the result is instead 0x7FFFFFFFFFFFFFFF (sum looked negative) or 0x8000000000000000 (sum looked positive), with overflow. Operands of opposite sign never overflow.
- R4: Opcode 2 (clip, U in 0..30): the signed operand is limited to [-(2^U), 2^U-1]. Clipping raises no overflow.
- R5: Opcode 3 (convergent round): when operand bits [1:0] are both 1, the result is operand+1 (mod 2^64). Otherwise the operand passes unchanged. No overflow is raised.
- R6: Opcode 4 (round to boundary): with N=0 the full operand passes unchanged. Otherwise the result is the sign-extended low 32 bits of the operand plus 2^(N-1). No overflow is raised.
- R7: N=0 for opcodes 0 and 1, U=31 for opcode 2, and opcodes 6 and 7 all return the operand unchanged with no overflow.
- R8: Result, out_valid and the overflow pulse change one clock after in_valid. The overflow pulse is only asserted together with out_valid. While in_valid is low, out_valid drops and result keeps its last value.
- R9: The sticky bit is set at the same edge as any overflow pulse and holds until an ovf_clear cycle. ovf_clear clears it at the next edge unless that same edge carries an overflow, in which case it stays set.
- R10: After reset, out_valid, result, the overflow pulse and the sticky bit are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 3 | Opcode (0 ssat, 1 usat, 2 clip, 3 crnd, 4 rbnd, 5 sadd) |
| opnd_a | input | 64 | Main operand |
| opnd_b | input | 64 | Second addend for opcode 5 |
| width_n | input | 6 | N for saturation and boundary rounding |
| width_u | input | 5 | U for clip |
| ovf_clear | input | 1 | Clears the sticky overflow bit |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Registered result |
| ovf_pulse | output | 1 | Overflow of the operation reported with out_valid |
| ovf_sticky | output | 1 | Sticky overflow status |

## Verification
All three outputs tied to an operation are due at the first rising edge after the cycle in which in_valid is high: the result, the overflow pulse and the updated sticky bit. The bench applies each request at a falling edge. It then reads all outputs at the next falling edge, halfway between the capturing edge and the edge after it. Idle and clear-only cycles are checked the same way, one edge after they are applied, so the sticky model and the held result are compared exactly when the registers settle.

// File: rtl/satrnd_pkg.sv
package satrnd_pkg;
  typedef enum logic [2:0] {
    OP_SSAT = 3'd0,
    OP_USAT = 3'd1,
    OP_CLIP = 3'd2,
    OP_CRND = 3'd3,
    OP_RBND = 3'd4,
    OP_SADD = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } sr_op_e;
endpackage

// File: rtl/satrnd_saturate.sv
// Signed or unsigned saturation to a runtime width n (R1, R2, R7).
module satrnd_saturate #(
  parameter int DW = 64,
  parameter int NW = 6
) (
  input  logic [DW-1:0] a,
  input  logic [NW-1:0] n,
  input  logic          uns,
  output logic [DW-1:0] res,
  output logic          ovf
);
  localparam logic [DW-1:0] ONES = '1;

  logic          n_ok;
  logic [NW-1:0] n_m1;
  logic [DW-1:0] tail_s, tail_u, smin, smax, umax;
  logic          fit;

  always_comb begin
    n_ok   = (n != '0) && (32'(n) < DW);
    n_m1   = n - 1'b1;
    tail_s = $signed(a) >>> n_m1;
    tail_u = a >> n;
    smin   = ONES << n_m1;
    smax   = ~smin;
    umax   = ~(ONES << n);
    fit    = uns ? (tail_u == '0) : ((tail_s == '0) || (tail_s == ONES));
    ovf    = n_ok && !fit;
    res    = a;
    if (ovf) begin
      if (uns) res = a[DW-1] ? '0 : umax;
      else     res = a[DW-1] ? smin : smax;
    end
  end
endmodule

// File: rtl/satrnd_addsat.sv
// Two's complement add clamped on sign-bit overflow (R3).
module satrnd_addsat #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          ovf
);
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] sum;

  always_comb begin
    sum = a + b;
    ovf = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
    res = sum;
    if (ovf) res = sum[DW-1] ? POS_MAX : NEG_MIN;
  end
endmodule

// File: rtl/satrnd_round.sv
// Clip, convergent rounding and boundary rounding; none flags overflow (R4, R5, R6).
module satrnd_round
  import satrnd_pkg::*;
#(
  parameter int DW   = 64,
  parameter int NW   = 6,
  parameter int UW   = 5,
  parameter int UMAX = 30,
  parameter int SRCW = 32
) (
  input  sr_op_e        op,
  input  logic [DW-1:0] a,
  input  logic [NW-1:0] n,
  input  logic [UW-1:0] u,
  output logic [DW-1:0] res
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] src_ext;

  generate
    if (SRCW < DW) begin : g_ext
      assign src_ext = {{(DW-SRCW){a[SRCW-1]}}, a[SRCW-1:0]};
    end else begin : g_full
      assign src_ext = a;
    end
  endgenerate

  logic [DW-1:0] hi, lo, clip_v, crnd_v, rbnd_v;
  logic [NW-1:0] n_m1;

  always_comb begin
    hi     = (ONE << u) - ONE;
    lo     = ~hi;
    clip_v = a;
    if (32'(u) <= UMAX) begin
      if ($signed(a) > $signed(hi))      clip_v = hi;
      else if ($signed(a) < $signed(lo)) clip_v = lo;
    end
    crnd_v = (&a[1:0]) ? a + ONE : a;
    n_m1   = n - 1'b1;
    rbnd_v = (n == '0) ? a : src_ext + (ONE << n_m1);
    case (op)
      OP_CLIP: res = clip_v;
      OP_CRND: res = crnd_v;
      OP_RBND: res = rbnd_v;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/dsp_satrnd_unit.sv
module dsp_satrnd_unit
  import satrnd_pkg::*;
#(
  parameter int DW   = 64,
  parameter int NW   = 6,
  parameter int UW   = 5,
  parameter int UMAX = 30,
  parameter int SRCW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [NW-1:0] width_n,
  input  logic [UW-1:0] width_u,
  input  logic          ovf_clear,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          ovf_pulse,
  output logic          ovf_sticky
);
  sr_op_e        opc;
  logic [DW-1:0] sat_res, add_res, rnd_res, nxt_res;
  logic          sat_ovf, add_ovf, nxt_ovf;

  assign opc = sr_op_e'(op);

  satrnd_saturate #(.DW(DW), .NW(NW)) u_sat (
    .a(opnd_a), .n(width_n), .uns(opc == OP_USAT),
    .res(sat_res), .ovf(sat_ovf)
  );

  satrnd_addsat #(.DW(DW)) u_add (
    .a(opnd_a), .b(opnd_b), .res(add_res), .ovf(add_ovf)
  );

  satrnd_round #(.DW(DW), .NW(NW), .UW(UW), .UMAX(UMAX), .SRCW(SRCW)) u_rnd (
    .op(opc), .a(opnd_a), .n(width_n), .u(width_u), .res(rnd_res)
  );

  always_comb begin
    case (opc)
      OP_SSAT, OP_USAT:          begin nxt_res = sat_res; nxt_ovf = sat_ovf; end
      OP_SADD:                   begin nxt_res = add_res; nxt_ovf = add_ovf; end
      OP_CLIP, OP_CRND, OP_RBND: begin nxt_res = rnd_res; nxt_ovf = 1'b0;    end
      default:                   begin nxt_res = opnd_a;  nxt_ovf = 1'b0;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      ovf_pulse  <= 1'b0;
      ovf_sticky <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      ovf_pulse  <= in_valid && nxt_ovf;
      ovf_sticky <= (in_valid && nxt_ovf) || (ovf_sticky && !ovf_clear);
      if (in_valid) result <= nxt_res;
    end
  end
endmodule

// File: rtl/satrnd_chk.sv
module satrnd_chk
  import satrnd_pkg::*;
#(
  parameter int DW = 64,
  parameter int NW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    op,
  input logic          a_msb,
  input logic          b_msb,
  input logic [NW-1:0] width_n,
  input logic          ovf_clear,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic          ovf_pulse,
  input logic          ovf_sticky
);
  p_pulse_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> out_valid);
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));
  p_add_opposite_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SADD && a_msb != b_msb) |=> !ovf_pulse);
  // R4, R5, R6: rounding and clip never report overflow
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_CLIP || op == OP_CRND || op == OP_RBND)) |=> !ovf_pulse);
  p_zero_width_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_SSAT || op == OP_USAT) && width_n == '0) |=> !ovf_pulse);
  p_sticky_set_r9: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> ovf_sticky);
  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_sticky && !ovf_clear) |=> ovf_sticky);
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    ovf_clear |=> (ovf_sticky == ovf_pulse));
endmodule

bind dsp_satrnd_unit satrnd_chk #(.DW(DW), .NW(NW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
  .a_msb(opnd_a[DW-1]), .b_msb(opnd_b[DW-1]), .width_n(width_n),
  .ovf_clear(ovf_clear), .out_valid(out_valid), .result(result),
  .ovf_pulse(ovf_pulse), .ovf_sticky(ovf_sticky)
);

// File: tb/tb_dsp_satrnd_unit.sv
`timescale 1ns/1ps
module tb_dsp_satrnd_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [5:0]  width_n = '0;
  logic [4:0]  width_u = '0;
  logic        ovf_clear = 1'b0;
  logic        out_valid, ovf_pulse, ovf_sticky;
  logic [63:0] result;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [63:0] last_res = '0;
  bit          exp_sticky = 1'b0;

  always #2 clk = ~clk;

  dsp_satrnd_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .width_n(width_n), .width_u(width_u), .ovf_clear(ovf_clear),
    .out_valid(out_valid), .result(result), .ovf_pulse(ovf_pulse), .ovf_sticky(ovf_sticky)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R3";
      default: return "R7";
    endcase
  endfunction

  // Reference model written from the requirements
  task automatic model(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                       input int n, input int u, output logic [63:0] r, output bit ov);
    logic signed [63:0] sa, lo, hi;
    logic signed [64:0] s65;
    logic [63:0] umax;
    sa = $signed(a);
    r  = a;
    ov = 1'b0;
    case (o)
      3'd0: if (n >= 1) begin
        hi = (64'sd1 <<< (n-1)) - 64'sd1;
        lo = -hi - 64'sd1;
        if (sa > hi)      begin r = hi; ov = 1'b1; end
        else if (sa < lo) begin r = lo; ov = 1'b1; end
      end
      3'd1: if (n >= 1) begin
        umax = (64'd1 << n) - 64'd1;
        if (sa < 0)         begin r = '0;   ov = 1'b1; end
        else if (a > umax)  begin r = umax; ov = 1'b1; end
      end
      3'd2: if (u <= 30) begin
        hi = (64'sd1 <<< u) - 64'sd1;
        lo = -(64'sd1 <<< u);
        if (sa > hi)      r = hi;
        else if (sa < lo) r = lo;
      end
      3'd3: if (a[1:0] == 2'b11) r = a + 64'd1;
      3'd4: if (n != 0) begin
        sa = $signed(a[31:0]);
        r  = sa + (64'sd1 <<< (n-1));
      end
      3'd5: begin
        s65 = $signed({a[63], a}) + $signed({b[63], b});
        if (s65 > 65'sh0_7FFF_FFFF_FFFF_FFFF)       begin r = 64'h7FFF_FFFF_FFFF_FFFF; ov = 1'b1; end
        else if (s65 < -65'sh0_8000_0000_0000_0000) begin r = 64'h8000_0000_0000_0000; ov = 1'b1; end
        else r = s65[63:0];
      end
      default: ;
    endcase
  endtask

  task automatic run_op(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                        input int n, input int u, input bit clr);
    logic [63:0] er;
    bit eo;
    string t;
    model(o, a, b, n, u, er, eo);
    t = tag_of(o);
    in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b;
    width_n = 6'(n); width_u = 5'(u); ovf_clear = clr;
    @(negedge clk);
    exp_sticky = eo || (exp_sticky && !clr);
    last_res = er;
    chk(t, "result", result, er);
    chk(t, "ovf_pulse", 64'(ovf_pulse), 64'(eo));
    chk("R8", "out_valid", 64'(out_valid), 64'd1);
    chk("R9", "ovf_sticky", 64'(ovf_sticky), 64'(exp_sticky));
  endtask

  task automatic idle(input bit clr);
    in_valid = 1'b0; ovf_clear = clr;
    opnd_a = {$urandom, $urandom};
    @(negedge clk);
    exp_sticky = exp_sticky && !clr;
    chk("R8", "idle out_valid", 64'(out_valid), 64'd0);
    chk("R8", "idle result held", result, last_res);
    chk("R8", "idle pulse", 64'(ovf_pulse), 64'd0);
    chk("R9", "idle sticky", 64'(ovf_sticky), 64'(exp_sticky));
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10", "out_valid", 64'(out_valid), 64'd0);
    chk("R10", "result", result, 64'd0);
    chk("R10", "ovf_pulse", 64'(ovf_pulse), 64'd0);
    chk("R10", "ovf_sticky", 64'(ovf_sticky), 64'd0);

    // R1 signed saturation edges
    run_op(3'd0, 64'd127, 0, 8, 0, 0);
    run_op(3'd0, -64'sd128, 0, 8, 0, 0);
    run_op(3'd0, 64'd128, 0, 8, 0, 0);
    run_op(3'd0, -64'sd129, 0, 8, 0, 0);
    idle(1'b0);
    idle(1'b1);
    // R2 unsigned saturation edges
    run_op(3'd1, 64'd255, 0, 8, 0, 0);
    run_op(3'd1, 64'd256, 0, 8, 0, 0);
    run_op(3'd1, -64'sd1, 0, 8, 0, 1);
    run_op(3'd1, 64'h7FFF_FFFF_FFFF_FFFF, 0, 63, 0, 1);
    // R3 saturating add
    run_op(3'd5, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0);
    run_op(3'd5, 64'h8000_0000_0000_0000, -64'sd1, 0, 0, 1);
    run_op(3'd5, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 0, 0, 1);
    run_op(3'd5, 64'd5, 64'd7, 0, 0, 0);
    // R4 clip
    run_op(3'd2, 64'd100, 0, 0, 4, 0);
    run_op(3'd2, -64'sd100, 0, 0, 4, 0);
    run_op(3'd2, 64'd5, 0, 0, 4, 0);
    run_op(3'd2, -64'sd1, 0, 0, 0, 0);
    // R5 convergent round
    run_op(3'd3, 64'd7, 0, 0, 0, 0);
    run_op(3'd3, 64'd6, 0, 0, 0, 0);
    run_op(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);
    // R6 round to boundary
    run_op(3'd4, 64'h1234_5678_8000_0000, 0, 0, 0, 0);
    run_op(3'd4, 64'h0000_0000_FFFF_FFFF, 0, 4, 0, 0);
    run_op(3'd4, 64'hABCD_0000_0000_0010, 0, 1, 0, 0);
    // R7 out of range widths and spare opcodes
    run_op(3'd0, 64'h8000_0000_0000_0000, 0, 0, 0, 0);
    run_op(3'd1, -64'sd5, 0, 0, 0, 0);
    run_op(3'd2, 64'h0123_4567_89AB_CDEF, 0, 0, 31, 0);
    run_op(3'd6, 64'hDEAD_BEEF_0000_0003, 0, 5, 5, 0);
    run_op(3'd7, 64'h7FFF_0000_0000_0000, 0, 5, 5, 0);
    // R9 clear and overflow in the same cycle: overflow wins
    run_op(3'd0, 64'd1000, 0, 4, 0, 1);
    idle(1'b1);
    idle(1'b0);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      int sh;
      sh = $urandom_range(0, 63);
      a  = 64'($signed({$urandom, $urandom}) >>> sh);
      b  = ($urandom_range(0, 3) == 0) ? {$urandom_range(0, 1) ? 2'b01 : 2'b10, 62'($urandom)} : {$urandom, $urandom};
      run_op(3'($urandom_range(0, 7)), a, b, $urandom_range(0, 63), $urandom_range(0, 31),
             $urandom_range(0, 7) == 0);
      if ($urandom_range(0, 9) == 0) idle($urandom_range(0, 1) == 1);
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule